// File: doc/BRIEF.md
# Ethernet Port Statistics Counter Bank

This block keeps four 32-bit statistics counters for one Ethernet port: received frames, received bytes, transmitted frames and transmitted bytes. The receive and transmit paths send it single-cycle event strobes. Each byte strobe carries a frame length that already includes the CRC bytes and leaves out the preamble and delimiter. The receive counters count every strobe they get, so they keep counting when the receive FIFO has dropped the frame.

A byte-wide host port reads the counters. Each counter appears in two address windows. A read through the clearing window zeroes the counter. A read through the preserving window leaves it as it is. A counter is read one byte at a time, lowest byte first, over consecutive reads. Reading byte 0 copies the whole counter into a holding register, so the upper bytes that follow all come from the same instant. When a counter wraps past its largest value, it sets a sticky overflow bit. The host clears these bits by writing ones to them.

Top module: `stat_bank`

## Requirements
- R1: After reset, every counter reads zero, the overflow register reads 0x00 and `host_rdata` is 0x00.
- R2: The counter map is: index 0 receive frames, index 1 receive bytes, index 2 transmit frames, index 3 transmit bytes. A byte of a counter sits at window base + 4*index + byte number. A frame strobe adds 1 to its counter. A byte strobe adds the zero-extended length input to its counter.
- R3: A read in the preserving window, at base 0x200, returns the addressed byte and leaves the counter unchanged.
- R4: A read of byte 0 in the clearing window, at base 0x100, returns byte 0 and sets the counter to zero. If a strobe for that counter arrives in the same cycle, the counter takes the strobe's amount instead of zero.
- R5: A read of byte 0 in either window copies the full counter into a holding register. A read of bytes 1 to 3 returns that byte from the holding register, whatever the counter has done since.
- R6: An increment that carries out of bit 31 leaves the wrapped value in the counter and sets bit n of the overflow register (address 0x010) for counter n. The bit stays set.
- R7: A host write to 0x010 clears each overflow bit whose `host_wdata` bit is 1. A wrap in the same cycle sets the bit anyway.
- R8: Host writes to either counter window change no counter.
- R9: `host_rdata` loads on the clock edge that samples `host_rd`, and holds its value until the next read. A read of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame_stb | input | 1 | One received frame |
| rx_byte_stb | input | 1 | Received byte amount is valid |
| rx_byte_len | input | LENW | Received frame length in bytes, including CRC |
| tx_frame_stb | input | 1 | One transmitted frame |
| tx_byte_stb | input | 1 | Transmitted byte amount is valid |
| tx_byte_len | input | LENW | Transmitted frame length in bytes, including CRC |
| host_addr | input | 10 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |

## Verification
A strobe and a host operation sampled at one edge take effect together on that edge. A read issued in one cycle can be checked in the next cycle, and the counter state it reports includes every strobe up to the cycle before. The bench drives inputs at the falling edge and updates its own model of counters, overflow bits and holding register as it does so. It compares `host_rdata` with the model at the following falling edge, after the edge that loaded it. The wrap case runs the transmit byte counter up to 0xFFFFFFFF with full-size lengths, then checks the next increment and the overflow register one read later.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE_CLR  = 10'h100;
  localparam logic [AW-1:0] BASE_KEEP = 10'h200;
  localparam logic [AW-1:0] ADDR_OVF  = 10'h010;

  typedef enum logic [1:0] {WIN_NONE, WIN_CLR, WIN_KEEP, WIN_OVF} win_e;
endpackage

// File: rtl/stat_ctr.sv
module stat_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_en,
  input  logic [CW-1:0] inc_amt,
  input  logic          clr,
  output logic [CW-1:0] value,
  output logic          wrap
);
  function automatic logic [CW:0] add_carry(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [CW-1:0] add;
  logic [CW:0]   sum;
  logic [CW-1:0] nxt;

  always_comb begin
    add  = inc_en ? inc_amt : '0;
    sum  = add_carry(value, add);
    nxt  = clr ? add : sum[CW-1:0];
    wrap = !clr && sum[CW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end
endmodule

// File: rtl/stat_host_dec.sv
module stat_host_dec
  import stat_pkg::*;
#(
  parameter int N_CNT = 4,
  parameter int CW    = 32,
  localparam int IW   = $clog2(N_CNT),
  localparam int BIW  = $clog2(CW / 8),
  localparam int OW   = IW + BIW
) (
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output win_e             win,
  output logic [IW-1:0]    sel,
  output logic [BIW-1:0]   lane,
  output logic             snap_en,
  output logic [N_CNT-1:0] clr_vec,
  output logic [N_CNT-1:0] ovf_w1c
);
  always_comb begin
    if (addr[AW-1:OW] == BASE_CLR[AW-1:OW])       win = WIN_CLR;
    else if (addr[AW-1:OW] == BASE_KEEP[AW-1:OW]) win = WIN_KEEP;
    else if (addr == ADDR_OVF)                    win = WIN_OVF;
    else                                          win = WIN_NONE;
    sel     = addr[OW-1:BIW];
    lane    = addr[BIW-1:0];
    snap_en = rd && (win == WIN_CLR || win == WIN_KEEP) && lane == '0;
    clr_vec = (rd && win == WIN_CLR && lane == '0) ? (N_CNT'(1) << sel) : '0;
    ovf_w1c = (wr && win == WIN_OVF) ? wdata[N_CNT-1:0] : '0;
  end
endmodule

// File: rtl/stat_rd_mux.sv
module stat_rd_mux
  import stat_pkg::*;
#(
  parameter int N_CNT = 4,
  parameter int CW    = 32,
  localparam int IW   = $clog2(N_CNT),
  localparam int BIW  = $clog2(CW / 8)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  win_e                win,
  input  logic [IW-1:0]       sel,
  input  logic [BIW-1:0]      lane,
  input  logic                snap_en,
  input  logic [N_CNT*CW-1:0] cnt_flat,
  input  logic [N_CNT-1:0]    ovf,
  output logic [7:0]          rdata
);
  logic [CW-1:0] live;
  logic [CW-1:0] snap;
  logic [7:0]    rd_byte;

  always_comb begin
    live = cnt_flat[int'(sel)*CW +: CW];
    case (win)
      WIN_CLR, WIN_KEEP: rd_byte = (lane == '0) ? live[7:0] : snap[{lane, 3'b000} +: 8];
      WIN_OVF:           rd_byte = 8'(ovf);
      default:           rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap  <= '0;
      rdata <= 8'h00;
    end else begin
      if (snap_en) snap  <= live;
      if (rd)      rdata <= rd_byte;
    end
  end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_pkg::*;
#(
  parameter int CW   = 32,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_frame_stb,
  input  logic            rx_byte_stb,
  input  logic [LENW-1:0] rx_byte_len,
  input  logic            tx_frame_stb,
  input  logic            tx_byte_stb,
  input  logic [LENW-1:0] tx_byte_len,
  input  logic [AW-1:0]   host_addr,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [7:0]      host_wdata,
  output logic [7:0]      host_rdata
);
  localparam int N_CNT = 4;
  localparam int IW    = $clog2(N_CNT);
  localparam int BIW   = $clog2(CW / 8);

  logic [N_CNT-1:0]    inc_en;
  logic [N_CNT*CW-1:0] amt_flat;
  logic [N_CNT*CW-1:0] cnt_flat;
  logic [N_CNT-1:0]    clr_vec;
  logic [N_CNT-1:0]    wrap_vec;
  logic [N_CNT-1:0]    ovf_w1c;
  logic [N_CNT-1:0]    ovf;
  win_e                win;
  logic [IW-1:0]       sel;
  logic [BIW-1:0]      lane;
  logic                snap_en;

  assign inc_en   = {tx_byte_stb, tx_frame_stb, rx_byte_stb, rx_frame_stb};
  assign amt_flat = {CW'(tx_byte_len), CW'(1), CW'(rx_byte_len), CW'(1)};

  stat_host_dec #(.N_CNT(N_CNT), .CW(CW)) u_dec (
    .addr(host_addr), .rd(host_rd), .wr(host_wr), .wdata(host_wdata),
    .win(win), .sel(sel), .lane(lane), .snap_en(snap_en),
    .clr_vec(clr_vec), .ovf_w1c(ovf_w1c)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_ctr
    stat_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .inc_en(inc_en[k]), .inc_amt(amt_flat[k*CW +: CW]), .clr(clr_vec[k]),
      .value(cnt_flat[k*CW +: CW]), .wrap(wrap_vec[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf <= '0;
    else        ovf <= (ovf & ~ovf_w1c) | wrap_vec;
  end

  stat_rd_mux #(.N_CNT(N_CNT), .CW(CW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(host_rd), .win(win), .sel(sel), .lane(lane),
    .snap_en(snap_en), .cnt_flat(cnt_flat), .ovf(ovf), .rdata(host_rdata)
  );
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int N_CNT = 4,
  parameter int CW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_CNT-1:0]    inc_en,
  input logic [N_CNT*CW-1:0] amt_flat,
  input logic [N_CNT*CW-1:0] cnt_flat,
  input logic [N_CNT-1:0]    clr_vec,
  input logic [N_CNT-1:0]    wrap_vec,
  input logic [N_CNT-1:0]    ovf_w1c,
  input logic [N_CNT-1:0]    ovf
);
  assert_one_clear_R4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(clr_vec));

  for (genvar k = 0; k < N_CNT; k++) begin : g_chk
    assert_clear_keeps_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[k] |=> cnt_flat[k*CW +: CW] == $past(inc_en[k] ? amt_flat[k*CW +: CW] : '0));
    assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en[k] && !clr_vec[k]) |=>
        cnt_flat[k*CW +: CW] == CW'($past(cnt_flat[k*CW +: CW]) + $past(amt_flat[k*CW +: CW])));
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_en[k] && !clr_vec[k]) |=> $stable(cnt_flat[k*CW +: CW]));
    assert_wrap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_vec[k] |=> ovf[k]);
    assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[k] && !ovf_w1c[k]) |=> ovf[k]);
  end
endmodule

bind stat_bank stat_bank_chk #(.N_CNT(N_CNT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .amt_flat(amt_flat), .cnt_flat(cnt_flat),
  .clr_vec(clr_vec), .wrap_vec(wrap_vec), .ovf_w1c(ovf_w1c), .ovf(ovf)
);

// File: tb/sim_stat_bank.sv
module sim_stat_bank;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rx_f, rx_b, tx_f, tx_b, rd, wr;
  logic [15:0] rx_len, tx_len;
  logic [9:0]  addr;
  logic [7:0]  wdata, rdata;

  stat_bank u0 (
    .clk(clk), .rst_n(rst_n), .rx_frame_stb(rx_f), .rx_byte_stb(rx_b), .rx_byte_len(rx_len),
    .tx_frame_stb(tx_f), .tx_byte_stb(tx_b), .tx_byte_len(tx_len), .host_addr(addr),
    .host_rd(rd), .host_wr(wr), .host_wdata(wdata), .host_rdata(rdata)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] m_cnt [4];
  logic [31:0] m_snap;
  logic [3:0]  m_ovf;
  logic [7:0]  m_rdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, update the model, compare at the next falling edge.
  task automatic step(input logic r, input logic w, input logic [9:0] a, input logic [7:0] wd,
                      input logic [3:0] ev, input logic [15:0] rl, input logic [15:0] tl,
                      input string req, input bit do_chk);
    bit clr_w, keep_w;
    logic [3:0] setb;
    logic [32:0] s;
    int k;
    int b;
    rd = r; wr = w; addr = a; wdata = wd;
    {tx_b, tx_f, rx_b, rx_f} = ev; rx_len = rl; tx_len = tl;
    clr_w  = a[9:4] == 6'h10;
    keep_w = a[9:4] == 6'h20;
    k = int'(a[3:2]); b = int'(a[1:0]);
    setb = 4'h0;
    if (r) begin
      if (clr_w || keep_w) m_rdata = (b == 0) ? m_cnt[k][7:0] : m_snap[b*8 +: 8];
      else if (a == 10'h010) m_rdata = {4'h0, m_ovf};
      else m_rdata = 8'h00;
      if ((clr_w || keep_w) && b == 0) m_snap = m_cnt[k];
    end
    for (int j = 0; j < 4; j++) begin
      logic [31:0] add;
      add = !ev[j] ? 32'd0 : (j == 1) ? {16'd0, rl} : (j == 3) ? {16'd0, tl} : 32'd1;
      if (r && clr_w && b == 0 && k == j) m_cnt[j] = add;
      else begin
        s = {1'b0, m_cnt[j]} + {1'b0, add};
        m_cnt[j] = s[31:0];
        setb[j] = s[32];
      end
    end
    m_ovf = (m_ovf & ~((w && a == 10'h010) ? wd[3:0] : 4'h0)) | setb;
    @(negedge clk);
    if (do_chk) check(req, {24'd0, rdata}, {24'd0, m_rdata});
  endtask

  task automatic read_ctr(input logic [9:0] base, input int k, input string req);
    for (int b = 0; b < 4; b++)
      step(1, 0, base + 10'(4*k + b), 8'h00, 4'h0, 16'd0, 16'd0, req, 1);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7301);
    rst_n = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
    rx_f = 0; rx_b = 0; tx_f = 0; tx_b = 0; rx_len = '0; tx_len = '0;
    for (int j = 0; j < 4; j++) m_cnt[j] = '0;
    m_snap = '0; m_ovf = '0; m_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata after reset", {24'd0, rdata}, 32'd0);
    for (int j = 0; j < 4; j++) read_ctr(10'h200, j, "R1 counter zero after reset");
    step(1, 0, 10'h010, 8'h00, 4'h0, 16'd0, 16'd0, "R1 overflow reg after reset", 1);

    // R2: frame and byte increments
    step(0, 0, 10'h000, 8'h00, 4'b0011, 16'd64, 16'd0, "R2", 0);
    step(0, 0, 10'h000, 8'h00, 4'b1111, 16'd1518, 16'd60, "R2", 0);
    step(0, 0, 10'h000, 8'h00, 4'b0101, 16'd0, 16'd0, "R2", 0);
    for (int j = 0; j < 4; j++) read_ctr(10'h200, j, "R2 counter value");

    // R3: preserving read twice gives the same value
    read_ctr(10'h200, 1, "R3 first read");
    read_ctr(10'h200, 1, "R3 second read unchanged");

    // R4: clearing read with a strobe in the same cycle
    step(1, 0, 10'h100, 8'h00, 4'b0001, 16'd0, 16'd0, "R4 clear read byte0", 1);
    read_ctr(10'h200, 0, "R4 same-cycle increment kept");
    read_ctr(10'h100, 2, "R4 clear read");
    read_ctr(10'h200, 2, "R4 counter cleared");

    // R5: snapshot coherence while the counter keeps moving
    step(1, 0, 10'h204, 8'h00, 4'h0, 16'd0, 16'd0, "R5 byte0", 1);
    step(1, 0, 10'h205, 8'h00, 4'b0010, 16'hFFFF, 16'd0, "R5 byte1 from snapshot", 1);
    step(1, 0, 10'h206, 8'h00, 4'b0010, 16'hFFFF, 16'd0, "R5 byte2 from snapshot", 1);
    step(1, 0, 10'h207, 8'h00, 4'b0010, 16'hFFFF, 16'd0, "R5 byte3 from snapshot", 1);

    // R8: writes to counter windows ignored
    step(0, 1, 10'h104, 8'hFF, 4'h0, 16'd0, 16'd0, "R8", 0);
    step(0, 1, 10'h200, 8'hFF, 4'h0, 16'd0, 16'd0, "R8", 0);
    read_ctr(10'h200, 1, "R8 bytes counter unchanged by writes");
    read_ctr(10'h200, 0, "R8 frames counter unchanged by writes");

    // R9: unmapped read returns zero, rdata holds without read
    step(1, 0, 10'h300, 8'h00, 4'h0, 16'd0, 16'd0, "R9 unmapped read", 1);
    step(1, 0, 10'h200, 8'h00, 4'h0, 16'd0, 16'd0, "R9 read", 1);
    step(0, 0, 10'h000, 8'h00, 4'b1111, 16'd9, 16'd9, "R9 rdata holds", 1);

    // R6: run transmit byte counter to all ones, then wrap
    step(1, 0, 10'h10C, 8'h00, 4'h0, 16'd0, 16'd0, "R6 clear tx bytes", 1);
    for (int i = 0; i < 65537; i++)
      step(0, 0, 10'h000, 8'h00, 4'b1000, 16'd0, 16'hFFFF, "R6", 0);
    read_ctr(10'h200, 3, "R6 counter at max");
    step(1, 0, 10'h010, 8'h00, 4'h0, 16'd0, 16'd0, "R6 no overflow before wrap", 1);
    step(0, 0, 10'h000, 8'h00, 4'b1000, 16'd0, 16'd2, "R6", 0);
    read_ctr(10'h200, 3, "R6 wrapped value");
    step(1, 0, 10'h010, 8'h00, 4'h0, 16'd0, 16'd0, "R6 overflow bit 3 set", 1);
    check("R6 overflow bit 3 set", {24'd0, rdata}, 32'h08);

    // R7: write-one-to-clear
    step(0, 1, 10'h010, 8'h01, 4'h0, 16'd0, 16'd0, "R7", 0);
    step(1, 0, 10'h010, 8'h00, 4'h0, 16'd0, 16'd0, "R7 other bit kept", 1);
    step(0, 1, 10'h010, 8'h08, 4'h0, 16'd0, 16'd0, "R7", 0);
    step(1, 0, 10'h010, 8'h00, 4'h0, 16'd0, 16'd0, "R7 bit cleared", 1);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      logic [9:0] a;
      op = $urandom % 10;
      case ($urandom % 4)
        0: a = 10'h100 | 10'($urandom % 16);
        1, 2: a = 10'h200 | 10'($urandom % 16);
        default: a = ($urandom % 2 == 0) ? 10'h010 : 10'h3F0;
      endcase
      step(op < 5, op == 9, a, 8'($urandom), 4'($urandom), 16'($urandom), 16'($urandom),
           "R2/R3/R4/R5/R9 random", 1);
    end
    for (int j = 0; j < 4; j++) read_ctr(10'h200, j, "R3 final values");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(150000 * 4);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule